// File: doc/BRIEF.md
# FIFO Level and Receive Idle Interrupt Generator

This block watches the occupancy of the transmit and receive queues of a serial controller, each up to eight entries deep. It produces three status flags and one combined interrupt. The transmit flag reports that the transmit queue has drained to a programmable low mark. The receive flag reports that the receive queue has filled past a programmable high mark. The idle flag reports that received data has been left unread for too long.

The idle interval is counted in controller clock cycles. It is short when the controller drives the serial clock (master role) and longer when the controller follows an external clock (slave role). The idle flag stays set until software acknowledges it with a one-cycle clear strobe. Each flag reaches the interrupt line only through its own enable.

Top module: `fifo_irq_gen`

## Requirements
- R1: `tx_flag` is 1 in the cycle after a clock edge at which `tx_level <= tx_mark` was sampled, and 0 otherwise.
- R2: `rx_flag` is 1 in the cycle after a clock edge at which `rx_level > rx_mark` was sampled, and 0 otherwise.
- R3: A clock edge qualifies when `rx_level` is nonzero, `rx_pop` and `rx_push` are 0, and `slave_mode` equals its value at the previous edge. With `slave_mode` = 0, `to_flag` rises right after the 64th consecutive qualifying edge.
- R4: With `slave_mode` = 1, `to_flag` rises right after the 576th consecutive qualifying edge.
- R5: `irq` equals (`tx_flag` & `tx_en`) | (`rx_flag` & `rx_en`) | (`to_flag` & `to_en`), with no added cycle of delay.
- R6: `to_flag` stays at 1 until an edge with `to_clear` = 1. If the idle interval completes at the same edge as a clear, the flag stays set.
- R7: Any edge that does not qualify restarts the idle count from zero. After the flag has fired, no further firing takes place until the count has been restarted. The edges that do not qualify are: an empty receive queue, a pop, a push, or a change of `slave_mode`.
- R8: While `rst_n` is 0, all flags and `irq` are 0, the idle count is zero, and the previous mode is taken as master (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | 4 | Number of valid transmit queue entries (0..8) |
| rx_level | input | 4 | Number of valid receive queue entries (0..8) |
| rx_push | input | 1 | One-cycle strobe: an entry was written into the receive queue |
| rx_pop | input | 1 | One-cycle strobe: an entry was read from the receive queue |
| tx_mark | input | 3 | Transmit low mark |
| rx_mark | input | 3 | Receive high mark |
| slave_mode | input | 1 | 1 selects the long idle interval, 0 the short one |
| tx_en | input | 1 | Lets the transmit flag reach `irq` |
| rx_en | input | 1 | Lets the receive flag reach `irq` |
| to_en | input | 1 | Lets the idle flag reach `irq` |
| to_clear | input | 1 | Write-one-to-clear strobe for `to_flag` |
| tx_flag | output | 1 | Transmit queue at or below its mark |
| rx_flag | output | 1 | Receive queue above its mark |
| to_flag | output | 1 | Sticky receive idle flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `rx_level` never exceeds the queue depth. They also assume that `rx_push` and `rx_pop` are single-cycle strobes sampled on the same edge as the level they affect, and that all inputs are stable and defined from reset onward. The stimulus draws levels only in 0..8 and drives every input to a known value before reset is released. It changes inputs only on falling edges. The long idle phases hold the receive level fixed and keep both strobes low, so the exact firing edge in each mode can be observed.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

   typedef enum logic {
      CMP_AT_OR_BELOW = 1'b0,
      CMP_ABOVE       = 1'b1
   } cmp_kind_e;

   typedef enum int unsigned {
      SRC_TX = 0,
      SRC_RX = 1,
      SRC_TO = 2
   } irq_src_e;

   localparam int unsigned NUM_SRC = 3;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/level_cmp.sv
module level_cmp
   import fifo_irq_pkg::*;
#(
   parameter int unsigned LW   = 4,
   parameter int unsigned TW   = 3,
   parameter cmp_kind_e   KIND = CMP_AT_OR_BELOW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic [TW-1:0] mark,
   output logic          flag
);

   localparam int unsigned PADW = LW - TW;

   generate
      if (TW > LW) begin : g_bad_width
         $error("level_cmp: mark wider than level");
      end
   endgenerate

   logic [LW-1:0] mark_ext;
   logic          hit;

   generate
      if (PADW == 0) begin : g_nopad
         assign mark_ext = mark;
      end else begin : g_pad
         assign mark_ext = {{PADW{1'b0}}, mark};
      end
   endgenerate

   generate
      if (KIND == CMP_AT_OR_BELOW) begin : g_le
         assign hit = (level <= mark_ext);
      end else begin : g_gt
         assign hit = (level > mark_ext);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= hit;
   end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
   import fifo_irq_pkg::*;
#(
   parameter int unsigned LW       = 4,
   parameter int unsigned IDLE_MST = 64,
   parameter int unsigned IDLE_SLV = 576
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic          push,
   input  logic          pop,
   input  logic          slave,
   input  logic          clear,
   output logic          flag
);

   localparam int unsigned IDLE_MAX = max_u(IDLE_MST, IDLE_SLV);
   localparam int unsigned CTW      = $clog2(IDLE_MAX + 1);

   generate
      if (IDLE_MST < 2 || IDLE_SLV < 2) begin : g_bad_idle
         $error("rx_idle_timer: idle intervals must be at least 2");
      end
   endgenerate

   logic [CTW-1:0] cnt_q;
   logic [CTW-1:0] limit;
   logic           slave_q;
   logic           restart;
   logic           expire;

   assign limit   = slave ? CTW'(IDLE_SLV) : CTW'(IDLE_MST);
   assign restart = (level == '0) || push || pop || (slave != slave_q);
   assign expire  = !restart && (cnt_q == limit - CTW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         slave_q <= 1'b0;
      end else begin
         slave_q <= slave;
         if (restart)           cnt_q <= '0;
         else if (cnt_q < limit) cnt_q <= cnt_q + CTW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (expire) flag <= 1'b1;
      else if (clear)  flag <= 1'b0;
   end

   AST_FIRE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(level != '0 && !push && !pop)); // R3
   AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clear) |=> flag); // R6
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CTW'(IDLE_MAX)); // R7
   AST_EMPTY_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && clear) |=> !flag); // R7

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] flags,
   input  logic [N-1:0] enables,
   output logic         irq
);

   logic [N-1:0] gated;

   generate
      for (genvar i = 0; i < N; i++) begin : g_gate
         assign gated[i] = flags[i] & enables[i];
      end
   endgenerate

   assign irq = |gated;

endmodule

// File: rtl/fifo_irq_gen.sv
module fifo_irq_gen
   import fifo_irq_pkg::*;
#(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned MARK_W   = 3,
   parameter int unsigned IDLE_MST = 64,
   parameter int unsigned IDLE_SLV = 576,
   localparam int unsigned LW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LW-1:0]     tx_level,
   input  logic [LW-1:0]     rx_level,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic [MARK_W-1:0] tx_mark,
   input  logic [MARK_W-1:0] rx_mark,
   input  logic              slave_mode,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              to_en,
   input  logic              to_clear,
   output logic              tx_flag,
   output logic              rx_flag,
   output logic              to_flag,
   output logic              irq
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fifo_irq_gen: DEPTH must be at least 2");
      end
      if (MARK_W > LW) begin : g_bad_mark
         $error("fifo_irq_gen: MARK_W exceeds level width");
      end
   endgenerate

   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] enables;

   level_cmp #(.LW(LW), .TW(MARK_W), .KIND(CMP_AT_OR_BELOW)) u_tx_cmp (
      .clk(clk), .rst_n(rst_n), .level(tx_level), .mark(tx_mark), .flag(tx_flag)
   );

   level_cmp #(.LW(LW), .TW(MARK_W), .KIND(CMP_ABOVE)) u_rx_cmp (
      .clk(clk), .rst_n(rst_n), .level(rx_level), .mark(rx_mark), .flag(rx_flag)
   );

   rx_idle_timer #(.LW(LW), .IDLE_MST(IDLE_MST), .IDLE_SLV(IDLE_SLV)) u_idle (
      .clk(clk), .rst_n(rst_n), .level(rx_level), .push(rx_push), .pop(rx_pop),
      .slave(slave_mode), .clear(to_clear), .flag(to_flag)
   );

   assign flags[SRC_TX]   = tx_flag;
   assign flags[SRC_RX]   = rx_flag;
   assign flags[SRC_TO]   = to_flag;
   assign enables[SRC_TX] = tx_en;
   assign enables[SRC_RX] = rx_en;
   assign enables[SRC_TO] = to_en;

   irq_merge #(.N(NUM_SRC)) u_merge (
      .flags(flags), .enables(enables), .irq(irq)
   );

   AST_TX_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0) |=> tx_flag); // R1
   AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == LW'(DEPTH)) |=> !tx_flag); // R1
   AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |=> !rx_flag); // R2
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !rx_en && !to_en) |-> !irq); // R5
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (tx_flag || rx_flag || to_flag)); // R5

endmodule

// File: tb/sim_fifo_irq_gen.sv
module sim_fifo_irq_gen;

   localparam int CLK_PERIOD = 10;
   localparam int LIM_M = 64;
   localparam int LIM_S = 576;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] tx_level = '0, rx_level = '0;
   logic       rx_push = 1'b0, rx_pop = 1'b0;
   logic [2:0] tx_mark = '0, rx_mark = '0;
   logic       slave_mode = 1'b0;
   logic       tx_en = 1'b0, rx_en = 1'b0, to_en = 1'b0, to_clear = 1'b0;
   logic       tx_flag, rx_flag, to_flag, irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // reference state
   bit m_tx = 0, m_rx = 0, m_to = 0, m_prev_slave = 0;
   int m_idle = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_irq_gen u0 (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .rx_push(rx_push), .rx_pop(rx_pop), .tx_mark(tx_mark), .rx_mark(rx_mark),
      .slave_mode(slave_mode), .tx_en(tx_en), .rx_en(rx_en), .to_en(to_en),
      .to_clear(to_clear), .tx_flag(tx_flag), .rx_flag(rx_flag),
      .to_flag(to_flag), .irq(irq)
   );

   task automatic check_bit(input string tag, input logic got, input bit exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
      end
   endtask

   task automatic compare_all();
      bit exp_irq;
      exp_irq = (m_tx & tx_en) | (m_rx & rx_en) | (m_to & to_en);
      check_bit("R1 tx_flag", tx_flag, m_tx);
      check_bit("R2 rx_flag", rx_flag, m_rx);
      check_bit(slave_mode ? "R4 to_flag" : "R3 to_flag", to_flag, m_to);
      check_bit("R5 irq", irq, exp_irq);
   endtask

   // Advance one edge: update model from inputs held now, then compare.
   task automatic step();
      int  lim;
      bit  qualify;
      bit  fire;
      lim = slave_mode ? LIM_S : LIM_M;
      // R7: empty, push, pop or a mode change interrupts the idle run
      qualify = (rx_level != 0) && !rx_push && !rx_pop && (slave_mode == m_prev_slave);
      fire = 0;
      if (!qualify) m_idle = 0;
      else begin
         m_idle++;
         if (m_idle == lim) fire = 1;
      end
      // R6: completion wins over clear
      if (fire) m_to = 1;
      else if (to_clear) m_to = 0;
      m_tx = (tx_level <= {1'b0, tx_mark});
      m_rx = (rx_level > {1'b0, rx_mark});
      m_prev_slave = slave_mode;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         rx_push = 0; rx_pop = 0; to_clear = 0;
         step();
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R8: reset state
      check_bit("R8 tx_flag", tx_flag, 0);
      check_bit("R8 rx_flag", rx_flag, 0);
      check_bit("R8 to_flag", to_flag, 0);
      check_bit("R8 irq", irq, 0);
      rst_n = 1;

      // R1, R2, R5: random levels, marks and enables with frequent traffic
      for (int i = 0; i < 400; i++) begin
         tx_level = 4'($urandom_range(8, 0));
         rx_level = 4'($urandom_range(8, 0));
         tx_mark  = 3'($urandom);
         rx_mark  = 3'($urandom);
         rx_push  = ($urandom_range(3, 0) == 0);
         rx_pop   = ($urandom_range(3, 0) == 0);
         tx_en    = 1'($urandom);
         rx_en    = 1'($urandom);
         to_en    = 1'($urandom);
         to_clear = 1'($urandom);
         step();
      end

      // R1/R2 boundaries: level equal to mark
      tx_level = 4'd5; tx_mark = 3'd5; rx_level = 4'd5; rx_mark = 3'd5;
      rx_push = 1; step();
      rx_push = 0; tx_level = 4'd6; rx_level = 4'd6; rx_pop = 1; step();
      rx_pop = 0; tx_level = 4'd8; tx_mark = 3'd7; rx_level = 4'd8; rx_mark = 3'd7; rx_push = 1; step();

      // R3: master idle interval, flag rises after the 64th quiet edge
      tx_en = 1; rx_en = 0; to_en = 1; to_clear = 1; slave_mode = 0;
      rx_level = 4'd3; rx_push = 1; step();
      idle(LIM_M + 6);
      // R6: sticky, then cleared
      idle(5);
      to_clear = 1; step(); to_clear = 0;
      // R7: no refire without restart
      idle(LIM_M + 4);

      // R7: pop restarts the run midway
      rx_pop = 1; step();
      idle(40);
      rx_pop = 1; step();
      idle(LIM_M + 2);

      // R6: clear at the very edge that completes the interval
      to_clear = 1; step();
      rx_push = 1; to_clear = 0; step();
      idle(LIM_M - 1);
      to_clear = 1; step();
      to_clear = 0; idle(3);

      // R4: slave idle interval
      to_clear = 1; rx_push = 1; slave_mode = 1; step();
      idle(LIM_S + 6);

      // R7: mode change restarts the count
      to_clear = 1; rx_push = 1; step();
      idle(100);
      slave_mode = 0; step();
      idle(LIM_M + 3);

      // R7: empty queue holds the count at zero
      to_clear = 1; step();
      rx_level = 4'd0; idle(LIM_M + 5);
      rx_level = 4'd1; idle(LIM_M + 2);

      // R5: enable sweep with all flags set
      tx_level = 0; rx_level = 4'd8; rx_mark = 0;
      for (int e = 0; e < 8; e++) begin
         tx_en = e[0]; rx_en = e[1]; to_en = e[2];
         rx_push = 0; rx_pop = 0; to_clear = 0;
         step();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule